// File: doc/BRIEF.md
# Oversampling Majority-Vote Serial Receiver

This block is the receive half of an asynchronous serial port. The raw receive line comes in unsynchronized. It first passes through a two-flop synchronizer. It is then sampled on an oversampling tick, which fires once every `div_i + 1` clocks. Sixteen ticks make up one bit period.

A falling edge seen between two consecutive tick samples while idle marks a candidate start bit. Every bit, the start bit included, is judged by a 2-of-3 majority over the samples taken at ticks 7, 8 and 9 of its bit period. A start bit that votes high is treated as noise and dropped. Eight data bits follow, least significant first. The first stop bit is then voted. A high stop bit delivers the byte with a one-cycle valid strobe. A low stop bit throws the byte away.

Returning to idle right after the stop-bit vote means one or two stop bits are accepted alike. Frames may also follow each other with no idle gap. Deasserting the enable abandons any frame in progress. While the enable is low, the line is only tracked, so a level that is already low at the moment of enabling never counts as a start.

Top module: `ovs_uart_rx`

## Requirements
- R1: While reset is applied, and directly after it, `rx_vld_o` is 0 and `rx_byte_o` is 0.
- R2: A well-formed frame is delivered on `rx_byte_o`. The frame is a low start bit, then 8 data bits with bit 0 first, then a high stop bit. `rx_vld_o` is high for the delivering cycle.
- R3: `rx_vld_o` is never high on two consecutive clocks.
- R4: Each bit is decided by a 2-of-3 majority over the samples at ticks 7, 8 and 9 of its bit period. A glitch that corrupts one tick sample near the centre of any bit (start, data or stop) leaves the delivered byte unchanged.
- R5: A low pulse on an idle line lasting one tick is rejected when the start-bit vote reads high. No byte is delivered, and the next proper frame is received normally.
- R6: A frame whose stop bit votes low raises no strobe. The frame after it is received normally.
- R7: Frames with one or two stop bits are both accepted. Frames sent back to back with no idle time between them are each delivered.
- R8: The oversampling tick fires every `div_i + 1` clocks while enabled. With a bit period of 16 ticks, frames are received correctly at `div_i` values of 0, 3 and 5.
- R9: While `rx_en_i` is low, no strobe is raised and line activity is ignored. Dropping `rx_en_i` in mid-frame abandons that frame, even after it is raised again before the frame ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_en_i | input | 1 | Receive enable; low forces idle and ignores the line |
| div_i | input | DIV_W (16) | Tick divisor; one tick every div_i+1 clocks |
| rxd_i | input | 1 | Asynchronous serial receive line, idle high |
| rx_byte_o | output | DATA_BITS (8) | Last delivered byte |
| rx_vld_o | output | 1 | One-cycle strobe marking a new byte |

## Verification
The bench keeps the default parameters of 8 data bits, 16 ticks per bit, 3 votes and a 2-stage synchronizer. It changes `div_i` at run time between 3, 0 and 5. With a divisor of 0 the tick fires every clock, which exercises vote windows exactly one clock wide and the tightest start-edge timing. A divisor of 5 checks that tick spacing and bit timing scale with the divisor. Glitches are always one tick long, so each corrupts exactly one oversample and lands on or beside the voting window.

// File: rtl/ovs_uart_rx_pkg.sv
package ovs_uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

endpackage

// File: rtl/ovr_rst_sync.sv
module ovr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = chain_q[STAGES-1];
endmodule

// File: rtl/ovr_rx_sync.sv
module ovr_rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] st_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= RST_VAL;
          else        st_q[g] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) st_q[g] <= RST_VAL;
          else        st_q[g] <= st_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ovr_rx_tick.sv
module ovr_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = en_i && (cnt_q == div_i);

  always_comb begin
    if (!en_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ovr_rx_vote.sv
module ovr_rx_vote #(
  parameter int OVS   = 16,
  parameter int VOTES = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick_i,
  input  logic [$clog2(OVS)-1:0] phase_i,
  input  logic                   sample_i,
  output logic                   done_o,
  output logic                   bit_o
);
  localparam int TW   = $clog2(OVS);
  localparam int CW   = $clog2(VOTES + 1);
  localparam int NEED = VOTES / 2 + 1;
  localparam logic [TW-1:0] V_LO = TW'(OVS / 2 - VOTES / 2);
  localparam logic [TW-1:0] V_HI = TW'(OVS / 2 - VOTES / 2 + VOTES - 1);

  logic [CW-1:0] ones_q, ones_d, ones_sum;
  logic          in_win;

  assign in_win   = (phase_i >= V_LO) && (phase_i <= V_HI);
  assign ones_sum = ((phase_i == V_LO) ? '0 : ones_q) + CW'(sample_i);
  assign done_o   = tick_i && (phase_i == V_HI);
  assign bit_o    = (ones_sum >= CW'(NEED));

  always_comb begin
    ones_d = ones_q;
    if (tick_i && in_win) ones_d = ones_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ones_q <= '0;
    else        ones_q <= ones_d;
  end
endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
  import ovs_uart_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int OVS         = 16,
  parameter int VOTES       = 3,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_en_i,
  input  logic [DIV_W-1:0]     div_i,
  input  logic                 rxd_i,
  output logic [DATA_BITS-1:0] rx_byte_o,
  output logic                 rx_vld_o
);
  localparam int TW = $clog2(OVS);
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [TW-1:0] PH_LAST   = TW'(OVS - 1);
  localparam logic [BW-1:0] BIDX_LAST = BW'(DATA_BITS - 1);

  logic rst_sn, rx_s, tick, vote_done, vote_bit;

  rx_state_e            state_q, state_d;
  logic [TW-1:0]        phase_q, phase_d;
  logic [BW-1:0]        bidx_q, bidx_d;
  logic [DATA_BITS-1:0] sh_q, sh_d;
  logic [DATA_BITS-1:0] byte_q, byte_d;
  logic                 line_q, line_d;
  logic                 vld_q, vld_d;

  ovr_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  ovr_rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(rxd_i), .q_o(rx_s)
  );

  ovr_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_sn), .en_i(rx_en_i), .div_i(div_i), .tick_o(tick)
  );

  ovr_rx_vote #(.OVS(OVS), .VOTES(VOTES)) u_vote (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick), .phase_i(phase_q),
    .sample_i(rx_s), .done_o(vote_done), .bit_o(vote_bit)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    bidx_d  = bidx_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    line_d  = line_q;
    vld_d   = 1'b0;
    if (!rx_en_i) begin
      state_d = RX_IDLE;
      phase_d = '0;
      bidx_d  = '0;
      line_d  = rx_s;
    end else if (tick) begin
      line_d = rx_s;
      if (phase_q == PH_LAST) phase_d = '0;
      else                    phase_d = phase_q + 1'b1;
      unique case (state_q)
        RX_IDLE: begin
          phase_d = '0;
          if (line_q && !rx_s) begin
            state_d = RX_START;
            phase_d = TW'(1);
          end
        end
        RX_START: begin
          if (vote_done && vote_bit) begin
            state_d = RX_IDLE;
            phase_d = '0;
          end else if (phase_q == PH_LAST) begin
            state_d = RX_DATA;
            bidx_d  = '0;
          end
        end
        RX_DATA: begin
          if (vote_done) sh_d = {vote_bit, sh_q[DATA_BITS-1:1]};
          if (phase_q == PH_LAST) begin
            if (bidx_q == BIDX_LAST) state_d = RX_STOP;
            else                     bidx_d  = bidx_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (vote_done) begin
            state_d = RX_IDLE;
            phase_d = '0;
            if (vote_bit) begin
              vld_d  = 1'b1;
              byte_d = sh_q;
            end
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= RX_IDLE;
      phase_q <= '0;
      bidx_q  <= '0;
      sh_q    <= '0;
      byte_q  <= '0;
      line_q  <= 1'b1;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bidx_q  <= bidx_d;
      sh_q    <= sh_d;
      byte_q  <= byte_d;
      line_q  <= line_d;
      vld_q   <= vld_d;
    end
  end

  assign rx_byte_o = byte_q;
  assign rx_vld_o  = vld_q;
endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk #(
  parameter int DIV_W     = 16,
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en,
  input logic [DIV_W-1:0]     div,
  input logic                 tick,
  input logic                 vld,
  input logic [DATA_BITS-1:0] byte_v
);
  logic [DIV_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (!en)  gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!vld && (byte_v == '0)));

  // R3
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);

  // R9
  off_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !vld);

  // R8
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
    tick |-> (gap_q == div));
endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.DIV_W(DIV_W), .DATA_BITS(DATA_BITS)) u_chk (
  .clk(clk), .rst_n(rst_sn), .en(rx_en_i), .div(div_i), .tick(tick),
  .vld(rx_vld_o), .byte_v(rx_byte_o)
);

// File: tb/sim_ovs_uart_rx.sv
`timescale 1ns/1ps
module sim_ovs_uart_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_en;
  logic [15:0] div;
  logic        rxd;
  logic [7:0]  rx_byte;
  logic        rx_vld;

  int   n_chk = 0;
  int   n_bad = 0;
  int   vld_cnt = 0;
  logic [7:0] last_byte = 8'h00;
  logic prev_vld = 1'b0;
  bit   finished = 1'b0;

  always #10 clk = ~clk;

  ovs_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .div_i(div), .rxd_i(rxd),
    .rx_byte_o(rx_byte), .rx_vld_o(rx_vld)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R3: strobe width monitor
  always @(negedge clk) begin
    if (rx_vld) begin
      vld_cnt++;
      last_byte = rx_byte;
      check(!prev_vld, "R3 strobe wider than one cycle", 1, 0);
    end
    prev_vld = rx_vld;
  end

  function automatic int tk();
    return int'(div) + 1;
  endfunction

  function automatic int bp();
    return 16 * tk();
  endfunction

  task automatic drive_bit(input logic v, input bit glitch);
    for (int k = 0; k < bp(); k++) begin
      @(negedge clk);
      rxd = (glitch && k >= 8 * tk() && k < 9 * tk()) ? ~v : v;
    end
  endtask

  task automatic idle_bits(input int n);
    for (int k = 0; k < n * bp(); k++) begin
      @(negedge clk);
      rxd = 1'b1;
    end
  endtask

  // gbit: -1 none, 0 start, 1..8 data, 9 stop
  task automatic send_frame(input logic [7:0] b, input int nstop, input int gbit, input logic stopv);
    drive_bit(1'b0, gbit == 0);
    for (int i = 0; i < 8; i++) drive_bit(b[i], gbit == i + 1);
    drive_bit(stopv, gbit == 9);
    for (int s = 1; s < nstop; s++) drive_bit(1'b1, 1'b0);
  endtask

  task automatic expect_rx(input logic [7:0] b, input int nstop, input int gbit, input string req);
    int c0;
    c0 = vld_cnt;
    send_frame(b, nstop, gbit, 1'b1);
    idle_bits(2);
    check(vld_cnt == c0 + 1, req, vld_cnt - c0, 1);
    check(last_byte == b, req, int'(last_byte), int'(b));
  endtask

  task automatic set_div(input int d);
    @(negedge clk); rx_en = 1'b0; div = 16'(d);
    @(negedge clk); rx_en = 1'b1;
    idle_bits(1);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(rx_vld == 1'b0, "R1 valid in reset", int'(rx_vld), 0);
    check(rx_byte == 8'h00, "R1 byte in reset", int'(rx_byte), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rx_vld == 1'b0, "R1 valid after reset", int'(rx_vld), 0);
    check(rx_byte == 8'h00, "R1 byte after reset", int'(rx_byte), 0);
  endtask

  task automatic t_basic();
    expect_rx(8'hA5, 1, -1, "R2 frame A5");
    expect_rx(8'h00, 1, -1, "R2 frame 00");
    expect_rx(8'hFF, 1, -1, "R2 frame FF");
    expect_rx(8'h01, 1, -1, "R2 frame 01 lsb first");
    expect_rx(8'h80, 1, -1, "R2 frame 80 lsb first");
  endtask

  task automatic t_glitch();
    for (int g = 0; g <= 9; g++) expect_rx(8'h3C ^ 8'(g), 1, g, "R4 glitch tolerated");
  endtask

  task automatic t_start_glitch();
    int c0;
    c0 = vld_cnt;
    for (int k = 0; k < tk(); k++) begin
      @(negedge clk); rxd = 1'b0;
    end
    idle_bits(3);
    check(vld_cnt == c0, "R5 false start rejected", vld_cnt - c0, 0);
    expect_rx(8'h5A, 1, -1, "R5 frame after false start");
  endtask

  task automatic t_bad_stop();
    int c0;
    c0 = vld_cnt;
    send_frame(8'h66, 1, -1, 1'b0);
    idle_bits(2);
    check(vld_cnt == c0, "R6 low stop discarded", vld_cnt - c0, 0);
    expect_rx(8'h99, 1, -1, "R6 frame after bad stop");
  endtask

  task automatic t_stops();
    int c0;
    expect_rx(8'hC3, 2, -1, "R7 two stop bits");
    c0 = vld_cnt;
    send_frame(8'h12, 1, -1, 1'b1);
    send_frame(8'h34, 2, -1, 1'b1);
    send_frame(8'hE7, 1, -1, 1'b1);
    idle_bits(2);
    check(vld_cnt == c0 + 3, "R7 back to back count", vld_cnt - c0, 3);
    check(last_byte == 8'hE7, "R7 back to back last byte", int'(last_byte), 'hE7);
  endtask

  task automatic t_divisor();
    set_div(0);
    expect_rx(8'h4B, 1, -1, "R8 divisor 0");
    expect_rx(8'hB4, 1, 4, "R8 divisor 0 glitch");
    set_div(5);
    expect_rx(8'h2D, 2, -1, "R8 divisor 5");
    expect_rx(8'hD2, 1, 7, "R8 divisor 5 glitch");
    set_div(3);
  endtask

  task automatic t_enable();
    int c0;
    logic [7:0] b;
    c0 = vld_cnt;
    @(negedge clk); rx_en = 1'b0;
    send_frame(8'h77, 1, -1, 1'b1);
    idle_bits(1);
    check(vld_cnt == c0, "R9 disabled frame ignored", vld_cnt - c0, 0);
    @(negedge clk); rx_en = 1'b1;
    idle_bits(1);
    // abandon mid-frame: byte F0, enable dropped in bit 1, restored in bit 2
    b = 8'hF0;
    c0 = vld_cnt;
    drive_bit(1'b0, 1'b0);
    drive_bit(b[0], 1'b0);
    for (int k = 0; k < bp(); k++) begin
      @(negedge clk); rxd = b[1];
      if (k == bp() / 2) rx_en = 1'b0;
    end
    for (int k = 0; k < bp(); k++) begin
      @(negedge clk); rxd = b[2];
      if (k == bp() / 2) rx_en = 1'b1;
    end
    for (int i = 3; i < 8; i++) drive_bit(b[i], 1'b0);
    drive_bit(1'b1, 1'b0);
    idle_bits(2);
    check(vld_cnt == c0, "R9 abandoned frame", vld_cnt - c0, 0);
    expect_rx(8'h81, 1, -1, "R9 frame after re-enable");
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rx_en = 1'b1;
    div   = 16'd3;
    rxd   = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    idle_bits(1);
    t_basic();
    t_glitch();
    t_start_glitch();
    t_bad_stop();
    t_stops();
    t_divisor();
    t_enable();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule